// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Result Registers

This block keeps the two architectural result registers of an integer core, HI and LO, and performs the operations that write them. Signed and unsigned multiplies write the 64-bit product into the pair in a single cycle. Signed and unsigned divides run on an iterative restoring divider. Two move operations load HI or LO directly from the `rs` operand. The value of either register can be read at any time through a select input.

The issuing logic raises `start` for one cycle with an operation code and both operands. A start is accepted only while `busy` is low. `done` pulses for one cycle when the result registers hold the outcome of the accepted operation. Divides keep `busy` high for 33 cycles: 32 iteration cycles and one sign-correction cycle. During that time the read port keeps showing the old register contents, so the issuer waits for `done` before it reads the new result.

Top module: `muldiv_hilo`

## Requirements
- R1: Op code 0 (signed multiply) writes the upper half of the signed 64-bit product of rs and rt into HI and the lower half into LO. done is high in the cycle after acceptance, and busy never rises.
- R2: Op code 1 (unsigned multiply) writes the unsigned 64-bit product, split the same way as for op code 0, with the same one-cycle timing.
- R3: Op code 2 (signed divide) puts the quotient of rs/rt in LO and the remainder in HI. The quotient truncates toward zero and the remainder takes the sign of rs. 0x80000000 / 0xFFFFFFFF gives LO=0x80000000 and HI=0.
- R4: Op code 3 (unsigned divide) puts the unsigned quotient in LO and the unsigned remainder in HI.
- R5: A divide whose rt is zero completes with the normal latency and done pulse, and leaves HI and LO unchanged.
- R6: After a divide is accepted, busy is high for exactly 33 cycles. done is high for one cycle right after busy falls and is never high together with busy.
- R7: Op code 4 loads rs into HI and op code 5 loads rs into LO. The other register is kept, and done is high in the next cycle.
- R8: rd_data shows HI when rd_sel is 1 and LO when rd_sel is 0. While busy is high, rd_data keeps the value it had before the divide.
- R9: A start while busy is high is ignored: it changes neither HI, LO nor the divide in progress.
- R10: Op codes 6 and 7 are ignored: no done pulse, and HI and LO do not change.
- R11: Reset clears HI, LO, busy and done, including in the middle of a divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request strobe |
| op | input | 3 | Operation code (0..5 valid) |
| rs | input | W | First operand / dividend / move source |
| rt | input | W | Second operand / divisor |
| rd_sel | input | 1 | Read select: 1 = HI, 0 = LO |
| rd_data | output | W | Selected result register |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench covers the sign cases of division: each sign combination of dividend and divisor, and the most-negative dividend divided by minus one. A design that corrected the signs wrongly would return a remainder with the divisor's sign, or would overflow the quotient in that last case. Division by zero is checked against the values HI and LO held before it; a design that wrote the garbage quotient would fail. The bench counts the busy cycles of every divide, reads the port while a divide is running, and issues a move while busy. This catches a divider that is off by one iteration, results that appear before done, and a start that should have been ignored but overwrote HI. Undefined op codes and a reset in the middle of a divide are also checked.

// File: rtl/md_pkg.sv
package md_pkg;
   typedef enum logic [2:0] {
      OP_MULT  = 3'd0,
      OP_MULTU = 3'd1,
      OP_DIV   = 3'd2,
      OP_DIVU  = 3'd3,
      OP_MTHI  = 3'd4,
      OP_MTLO  = 3'd5
   } md_op_e;

   typedef enum logic [1:0] {
      DV_IDLE = 2'd0,
      DV_RUN  = 2'd1,
      DV_FIX  = 2'd2
   } dv_state_e;
endpackage

// File: rtl/md_mult.sv
module md_mult #(
   parameter int W = 32
) (
   input  logic           sgn,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2 * W;

   logic [PW-1:0] ax;
   logic [PW-1:0] bx;

   // Extend both operands to the product width (sign or zero fill).
   // A truncated multiply then gives the right result for both signednesses.
   assign ax   = {{W{sgn & a[W-1]}}, a};
   assign bx   = {{W{sgn & b[W-1]}}, b};
   assign prod = ax * bx;
endmodule

// File: rtl/md_div.sv
module md_div
   import md_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic         sgn,
   input  logic [W-1:0] dvd,
   input  logic [W-1:0] dvs,
   output logic         busy,
   output logic         fix,
   output logic         zero,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   localparam int CW = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   dv_state_e    st_q;
   logic [CW-1:0] cnt_q;
   logic [W-1:0]  acc_q;
   logic [W-1:0]  q_q;
   logic [W-1:0]  dvs_q;
   logic          neg_q_q;
   logic          neg_r_q;
   logic          zero_q;

   logic [W:0]    shifted;
   logic [W:0]    trial;

   assign shifted = {acc_q, q_q[W-1]};
   assign trial   = shifted - {1'b0, dvs_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= DV_IDLE;
         cnt_q   <= '0;
         acc_q   <= '0;
         q_q     <= '0;
         dvs_q   <= '0;
         neg_q_q <= 1'b0;
         neg_r_q <= 1'b0;
         zero_q  <= 1'b0;
      end else begin
         case (st_q)
            DV_IDLE: begin
               if (go) begin
                  q_q     <= (sgn && dvd[W-1]) ? -dvd : dvd;
                  dvs_q   <= (sgn && dvs[W-1]) ? -dvs : dvs;
                  neg_q_q <= sgn && (dvd[W-1] ^ dvs[W-1]);
                  neg_r_q <= sgn && dvd[W-1];
                  zero_q  <= (dvs == '0);
                  acc_q   <= '0;
                  cnt_q   <= '0;
                  st_q    <= DV_RUN;
               end
            end
            DV_RUN: begin
               if (!trial[W]) begin
                  acc_q <= trial[W-1:0];
                  q_q   <= {q_q[W-2:0], 1'b1};
               end else begin
                  acc_q <= shifted[W-1:0];
                  q_q   <= {q_q[W-2:0], 1'b0};
               end
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST) st_q <= DV_FIX;
            end
            default: st_q <= DV_IDLE;
         endcase
      end
   end

   assign busy = (st_q != DV_IDLE);
   assign fix  = (st_q == DV_FIX);
   assign zero = zero_q;
   assign quo  = neg_q_q ? -q_q : q_q;
   assign rem  = neg_r_q ? -acc_q : acc_q;

   // R6: the correction step is always followed by an idle unit
   a_r6_fix_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      fix |=> !busy);
   // R6: an accepted divide makes the unit busy in the next cycle
   a_r6_go_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy) |=> (busy && !fix));
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
   import md_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [2:0]   op,
   input  logic [W-1:0] rs,
   input  logic [W-1:0] rt,
   input  logic         rd_sel,
   output logic [W-1:0] rd_data,
   output logic         busy,
   output logic         done
);
   localparam int PW = 2 * W;

   generate
      if (W < 2) begin : g_bad_width
         $error("muldiv_hilo: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  hi_q;
   logic [W-1:0]  lo_q;
   logic          done_q;
   logic          accept;
   logic          is_div;
   logic          is_mul;
   logic          div_go;
   logic [PW-1:0] prod;
   logic          dv_busy;
   logic          dv_fix;
   logic          dv_zero;
   logic [W-1:0]  dv_quo;
   logic [W-1:0]  dv_rem;

   assign accept = start && !dv_busy;
   assign is_div = (op == OP_DIV) || (op == OP_DIVU);
   assign is_mul = (op == OP_MULT) || (op == OP_MULTU);
   assign div_go = accept && is_div;

   md_mult #(.W(W)) i_mult (
      .sgn  (op == OP_MULT),
      .a    (rs),
      .b    (rt),
      .prod (prod)
   );

   md_div #(.W(W)) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .sgn   (op == OP_DIV),
      .dvd   (rs),
      .dvs   (rt),
      .busy  (dv_busy),
      .fix   (dv_fix),
      .zero  (dv_zero),
      .quo   (dv_quo),
      .rem   (dv_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept && is_mul) begin
            hi_q   <= prod[PW-1:W];
            lo_q   <= prod[W-1:0];
            done_q <= 1'b1;
         end else if (accept && op == OP_MTHI) begin
            hi_q   <= rs;
            done_q <= 1'b1;
         end else if (accept && op == OP_MTLO) begin
            lo_q   <= rs;
            done_q <= 1'b1;
         end
         if (dv_fix) begin
            if (!dv_zero) begin
               hi_q <= dv_rem;
               lo_q <= dv_quo;
            end
            done_q <= 1'b1;
         end
      end
   end

   assign rd_data = rd_sel ? hi_q : lo_q;
   assign busy    = dv_busy;
   assign done    = done_q;

   // R6: completion never overlaps an operation in progress
   a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R8/R9: results stay put while the divider iterates, whatever start does
   a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !dv_fix) |=> ($stable(hi_q) && $stable(lo_q)));
   // R5: a zero divisor leaves both registers untouched
   a_r5_zero_div_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (dv_fix && dv_zero) |=> ($stable(hi_q) && $stable(lo_q) && done));
   // R7: move-to-HI takes rs and keeps LO
   a_r7_move_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op == 3'd4) |=> (hi_q == $past(rs) && $stable(lo_q)));
   // R10: undefined codes have no effect
   a_r10_undef_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op[2:1] == 2'b11) |=> (!done && $stable(hi_q) && $stable(lo_q)));
endmodule

// File: tb/test_muldiv_hilo.sv
module test_muldiv_hilo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [31:0] rs = '0;
   logic [31:0] rt = '0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic        busy;
   logic        done;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   muldiv_hilo #(.W(32)) i_muldiv_hilo (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rs(rs), .rt(rt),
      .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy), .done(done)
   );

   // op, rs, rt, expected HI, expected LO
   localparam logic [130:0] TBL [15] = '{
      {3'd0, 32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFE},
      {3'd1, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 32'hFFFFFFFE},
      {3'd0, 32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000},
      {3'd1, 32'h00010000, 32'h00010000, 32'h00000001, 32'h00000000},
      {3'd3, 32'd100,      32'd7,        32'h00000002, 32'h0000000E},
      {3'd2, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFD},
      {3'd2, 32'h00000007, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFD},
      {3'd2, 32'hFFFFFFF9, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h00000003},
      {3'd2, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000},
      {3'd3, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'h00000000},
      {3'd3, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'hFFFFFFFF},
      {3'd4, 32'h12345678, 32'h0,        32'h12345678, 32'hFFFFFFFF},
      {3'd5, 32'hCAFEBABE, 32'h0,        32'h12345678, 32'hCAFEBABE},
      {3'd2, 32'h00000005, 32'h0,        32'h12345678, 32'hCAFEBABE},
      {3'd3, 32'h00000005, 32'h0,        32'h12345678, 32'hCAFEBABE}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic read_hilo(output logic [31:0] h, output logic [31:0] l);
      rd_sel = 1'b1; #1; h = rd_data;
      rd_sel = 1'b0; #1; l = rd_data;
   endtask

   // Issue one op at a negedge and wait for done; return the busy cycle count.
   // When inject is set, a move-to-HI start is pulsed while busy (R9) and the
   // read port is sampled mid-divide (R8) against hold_lo.
   task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input bit inject, input logic [31:0] hold_lo,
                        output int bcyc, output bit got_done);
      @(negedge clk);
      op = o; rs = a; rt = b; start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      bcyc = 0; got_done = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (inject && k == 3) begin
            rd_sel = 1'b0; #1;
            chk("R8 read held while busy", rd_data, hold_lo);
            op = 3'd4; rs = 32'hDEAD0000; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         if (done) begin got_done = 1; break; end
         if (busy) bcyc++;
      end
      start = 1'b0;
   endtask

   initial begin
      logic [31:0] h, l;
      int bc;
      bit gd;
      #20;
      // R11 reset state
      read_hilo(h, l);
      chk("R11 reset HI", h, 32'h0);
      chk("R11 reset LO", l, 32'h0);
      chk("R11 reset busy", {31'b0, busy}, 32'h0);
      chk("R11 reset done", {31'b0, done}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < 15; i++) begin
         logic [2:0] vo;
         string tag;
         vo = TBL[i][130:128];
         case (vo)
            3'd0: tag = "R1";
            3'd1: tag = "R2";
            3'd2: tag = "R3";
            3'd3: tag = "R4";
            default: tag = "R7";
         endcase
         if ((vo == 3'd2 || vo == 3'd3) && TBL[i][95:64] == 32'h0) tag = "R5";
         issue(vo, TBL[i][127:96], TBL[i][95:64], 1'b0, 32'h0, bc, gd);
         chk({tag, " done seen"}, {31'b0, gd}, 32'h1);
         chk({(vo == 3'd2 || vo == 3'd3) ? "R6" : tag, " busy cycles"}, bc,
             (vo == 3'd2 || vo == 3'd3) ? 32'd33 : 32'd0);
         read_hilo(h, l);
         chk({tag, " HI"}, h, TBL[i][63:32]);
         chk({tag, " LO"}, l, TBL[i][31:0]);
      end

      // R6: done is a single-cycle pulse
      @(negedge clk);
      chk("R6 done one cycle", {31'b0, done}, 32'h0);

      // R9 + R8: start while busy ignored, reads held during divide
      issue(3'd3, 32'd100, 32'd7, 1'b1, 32'hCAFEBABE, bc, gd);
      chk("R9 divide latency unchanged", bc, 32'd33);
      read_hilo(h, l);
      chk("R9 HI not overwritten", h, 32'h00000002);
      chk("R9 LO", l, 32'h0000000E);

      // R10: undefined op codes
      for (int u = 6; u < 8; u++) begin
         issue(3'(u), 32'h55555555, 32'h0, 1'b0, 32'h0, bc, gd);
         chk("R10 no done", {31'b0, gd}, 32'h0);
         read_hilo(h, l);
         chk("R10 HI kept", h, 32'h00000002);
         chk("R10 LO kept", l, 32'h0000000E);
      end

      // R11: reset in the middle of a divide
      @(negedge clk);
      op = 3'd2; rs = 32'd50; rt = 32'd3; start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b0; #1;
      read_hilo(h, l);
      chk("R11 mid reset busy", {31'b0, busy}, 32'h0);
      chk("R11 mid reset HI", h, 32'h0);
      chk("R11 mid reset LO", l, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      repeat (40) @(negedge clk);
      chk("R11 no late done", {31'b0, done}, 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule